// File: doc/BRIEF.md
# Associative Page Frame Directory

This block translates page numbers for a paged main store that keeps one register per physical page frame. Each frame register records which virtual page currently lives in that frame, together with a valid flag and a usage flag. Every access presents its virtual page number and word offset. The page number is compared with all frame registers at once. The index of the single matching register is the frame number, and that frame number is placed in front of the word offset to form the physical word address. When no register matches, the block reports a page fault instead.

For the fault handler, the block always shows a frame to fill. It offers the lowest free frame if there is one. Otherwise it offers the lowest frame whose usage flag is clear, and it also shows the page number that frame would evict. The handler then rewrites that frame's register, or invalidates a register. A periodic sweep input clears all usage flags.

A second part tracks which secondary-store slots are taken, using a bitmap. It always offers the lowest empty slot, so that a written-back page lands in the first free place.

Top module: `page_frame_dir`

## Requirements
- R1: After a synchronous active-low reset, every frame is invalid and every usage flag is clear. All secondary slots are empty, `rsp_valid`, `rsp_hit` and `rsp_fault` are 0, `alloc_frame` is 0 with `alloc_kind` 0, and `slot_idx` is 0 with `slot_avail` 1.
- R2: When `lk_en` is high at an edge and `lk_vpn` equals the page of valid frame f, then after that edge `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and `rsp_paddr` = {f (5 bits), `lk_off` (9 bits)}. These outputs hold until the next edge. At most one valid frame ever matches.
- R3: When a looked-up page matches no valid frame, then after that edge `rsp_valid`=1, `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0. An edge with `lk_en` low leaves all three flags at 0.
- R4: When any frame is invalid, `alloc_frame` is the lowest-index invalid frame and `alloc_kind` is 0 (free frame). `evict_vpn` is then 0.
- R5: When all frames are valid, `alloc_frame` is the lowest-index frame whose usage flag is clear, with `alloc_kind` 1. If every usage flag is set, `alloc_frame` is 0 with `alloc_kind` 2. In both cases `evict_vpn` is the page held by `alloc_frame`.
- R6: A hit sets the usage flag of the matching frame. A high `sweep_en` clears every usage flag, except that a hit in the same cycle leaves its own frame's flag set.
- R7: `inst_en` writes `inst_vpn` into frame `inst_frame` and marks that frame valid and used. It takes priority over an invalidate of the same frame. A lookup in the same cycle is compared against the old contents.
- R8: `inv_en` marks frame `inv_frame` invalid and clears its usage flag. Later lookups of its page fault.
- R9: `slot_idx` is the lowest empty slot of 192, and `slot_avail` shows that one exists. `slot_claim` with `slot_avail` marks that slot taken. `slot_release` frees slot `slot_rel_idx` in the same edge. A claim while the store is full changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_en | input | 1 | Lookup request this cycle |
| lk_vpn | input | 8 | Virtual page number to translate |
| lk_off | input | 9 | Word offset within the page |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_hit | output | 1 | Lookup matched a frame |
| rsp_fault | output | 1 | Lookup matched no frame (page fault) |
| rsp_paddr | output | 14 | Frame number joined with word offset |
| sweep_en | input | 1 | Clear all usage flags |
| alloc_frame | output | 5 | Frame offered to the fault handler |
| alloc_kind | output | 2 | 0 free, 1 idle victim, 2 forced victim |
| evict_vpn | output | 8 | Page held by the offered frame (0 if free) |
| inst_en | input | 1 | Write a frame register |
| inst_frame | input | 5 | Frame to write |
| inst_vpn | input | 8 | Page number to write |
| inv_en | input | 1 | Invalidate a frame register |
| inv_frame | input | 5 | Frame to invalidate |
| slot_claim | input | 1 | Take the offered secondary slot |
| slot_release | input | 1 | Free a secondary slot |
| slot_rel_idx | input | 8 | Slot to free |
| slot_idx | output | 8 | Lowest empty secondary slot |
| slot_avail | output | 1 | An empty slot exists |

## Verification
The bench fills every frame and then checks the victim choice in three states: with every usage flag set, which must force frame 0; after a sweep; and after an invalidate reopens a hole. A design that scanned from the wrong end, or that preferred idle frames over free ones, would offer the wrong frame. The bench also runs a sweep in the same cycle as a hit. A design that let the sweep win would offer the just-used frame as the victim. The secondary store is filled to all 192 slots and then has a middle slot freed. An encoder with an off-by-one error, or one that still reports space when the store is full, shows up at that point. Randomized lookups against a reference model check the translated address bits, so a swapped frame/offset join or a wrong match index would be caught.

// File: rtl/page_frame_dir_pkg.sv
// Shared constants and the victim-kind encoding for the page frame directory.
// Assumes: consumers size their ports from these defaults.
package page_frame_dir_pkg;
    localparam int DEF_FRAMES = 32;
    localparam int DEF_VPN_W  = 8;
    localparam int DEF_OFF_W  = 9;
    localparam int DEF_SLOTS  = 192;

    typedef enum logic [1:0] {
        KIND_FREE   = 2'd0,
        KIND_IDLE   = 2'd1,
        KIND_FORCED = 2'd2
    } alloc_kind_t;
endpackage

// File: rtl/lowest_set.sv
// Priority encoder: index of the lowest set bit of a vector and a found flag.
// Assumes: idx is 0 when no bit is set.
module lowest_set #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         found
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end

    assign found = |vec;
endmodule

// File: rtl/frame_cam.sv
// Per-frame page registers with parallel compare.
// Each frame holds a valid flag, a usage flag and the resident page number.
// Assumes: the fault handler never installs a page already resident elsewhere.
module frame_cam #(
    parameter int FRAMES  = 32,
    parameter int VPN_W   = 8,
    parameter int FRAME_W = $clog2(FRAMES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lk_en,
    input  logic [VPN_W-1:0]               lk_vpn,
    input  logic                           sweep_en,
    input  logic                           inst_en,
    input  logic [FRAME_W-1:0]             inst_frame,
    input  logic [VPN_W-1:0]               inst_vpn,
    input  logic                           inv_en,
    input  logic [FRAME_W-1:0]             inv_frame,
    output logic [FRAMES-1:0]              match_vec,
    output logic [FRAMES-1:0]              valid_vec,
    output logic [FRAMES-1:0]              used_vec,
    output logic [FRAMES-1:0][VPN_W-1:0]   vpn_vec
);
    // Parallel compare of the presented page against every valid frame.
    always_comb begin
        for (int f = 0; f < FRAMES; f++) begin
            match_vec[f] = valid_vec[f] && (vpn_vec[f] == lk_vpn);
        end
    end

    // Frame register update: install beats invalidate beats usage tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
            used_vec  <= '0;
            vpn_vec   <= '0;
        end else begin
            for (int f = 0; f < FRAMES; f++) begin
                if (inst_en && inst_frame == FRAME_W'(f)) begin
                    valid_vec[f] <= 1'b1;
                    used_vec[f]  <= 1'b1;
                    vpn_vec[f]   <= inst_vpn;
                end else if (inv_en && inv_frame == FRAME_W'(f)) begin
                    valid_vec[f] <= 1'b0;
                    used_vec[f]  <= 1'b0;
                end else if (lk_en && match_vec[f]) begin
                    used_vec[f]  <= 1'b1;
                end else if (sweep_en) begin
                    used_vec[f]  <= 1'b0;
                end
            end
        end
    end

    // A page must never be resident in two frames.
    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |-> $onehot0(match_vec));

    // An installed frame is valid on the following cycle.
    assert_install_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |=> valid_vec[$past(inst_frame)]);

    // Invalidate without a competing install empties the frame.
    assert_inval_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(inst_en && inst_frame == inv_frame)) |=> !valid_vec[$past(inv_frame)]);

    generate
        for (genvar g = 0; g < FRAMES; g++) begin : g_use_chk
            // A hit keeps the frame marked as used, even against a sweep.
            assert_hit_marks_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (lk_en && match_vec[g] && !(inv_en && inv_frame == FRAME_W'(g)))
                |=> used_vec[g]);
        end
    endgenerate
endmodule

// File: rtl/victim_pick.sv
// Chooses the frame offered to the fault handler: lowest free frame first,
// then the lowest valid frame with a clear usage flag, else frame 0.
// Assumes: an invalid frame always has a clear usage flag.
module victim_pick #(
    parameter int FRAMES  = 32,
    parameter int VPN_W   = 8,
    parameter int FRAME_W = $clog2(FRAMES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [FRAMES-1:0]             valid_vec,
    input  logic [FRAMES-1:0]             used_vec,
    input  logic [FRAMES-1:0][VPN_W-1:0]  vpn_vec,
    output logic [FRAME_W-1:0]            alloc_frame,
    output logic [1:0]                    alloc_kind,
    output logic [VPN_W-1:0]              evict_vpn
);
    import page_frame_dir_pkg::*;

    logic [FRAME_W-1:0] free_idx, idle_idx;
    logic               free_found, idle_found;
    alloc_kind_t        kind;

    lowest_set #(.N(FRAMES), .W(FRAME_W)) u_free (
        .vec(~valid_vec), .idx(free_idx), .found(free_found));

    lowest_set #(.N(FRAMES), .W(FRAME_W)) u_idle (
        .vec(valid_vec & ~used_vec), .idx(idle_idx), .found(idle_found));

    // Pick the offered frame by preference order.
    always_comb begin
        if (free_found) begin
            kind        = KIND_FREE;
            alloc_frame = free_idx;
        end else if (idle_found) begin
            kind        = KIND_IDLE;
            alloc_frame = idle_idx;
        end else begin
            kind        = KIND_FORCED;
            alloc_frame = '0;
        end
    end

    assign alloc_kind = kind;
    assign evict_vpn  = (kind == KIND_FREE) ? '0 : vpn_vec[alloc_frame];

    // A free offer really is an empty frame.
    assert_free_is_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_kind == KIND_FREE) |-> !valid_vec[alloc_frame]);

    // An idle offer is resident and unused.
    assert_idle_is_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_kind == KIND_IDLE) |-> (valid_vec[alloc_frame] && !used_vec[alloc_frame]));
endmodule

// File: rtl/slot_alloc.sv
// Occupancy bitmap for secondary-store slots; offers the lowest empty slot.
// Assumes: release and claim of the same slot are never issued together.
module slot_alloc #(
    parameter int SLOTS  = 192,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_claim,
    input  logic              slot_release,
    input  logic [SLOT_W-1:0] slot_rel_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_avail
);
    localparam logic [SLOTS-1:0] ONE = SLOTS'(1);

    logic [SLOTS-1:0] occ_q;
    logic [SLOTS-1:0] claim_mask, rel_mask;

    lowest_set #(.N(SLOTS), .W(SLOT_W)) u_enc (
        .vec(~occ_q), .idx(slot_idx), .found(slot_avail));

    // Masks for this cycle's claim and release.
    always_comb begin
        claim_mask = (slot_claim && slot_avail) ? (ONE << slot_idx) : '0;
        rel_mask   = slot_release ? (ONE << slot_rel_idx) : '0;
    end

    // Bitmap update.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= (occ_q | claim_mask) & ~rel_mask;
    end

    // A granted claim leaves that slot occupied.
    assert_claim_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_claim && slot_avail && !(slot_release && slot_rel_idx == slot_idx))
        |=> occ_q[$past(slot_idx)]);

    // The offered slot is never already occupied.
    assert_offer_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_avail |-> !occ_q[slot_idx]);
endmodule

// File: rtl/page_frame_dir.sv
// Top: associative page frame directory with registered translation result,
// fault-handler frame offer and secondary-slot allocator.
// Assumes: lookup result appears one cycle after the request.
module page_frame_dir #(
    parameter int FRAMES = page_frame_dir_pkg::DEF_FRAMES,
    parameter int VPN_W  = page_frame_dir_pkg::DEF_VPN_W,
    parameter int OFF_W  = page_frame_dir_pkg::DEF_OFF_W,
    parameter int SLOTS  = page_frame_dir_pkg::DEF_SLOTS,
    localparam int FRAME_W = $clog2(FRAMES),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_en,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [OFF_W-1:0]   lk_off,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    input  logic               sweep_en,
    output logic [FRAME_W-1:0] alloc_frame,
    output logic [1:0]         alloc_kind,
    output logic [VPN_W-1:0]   evict_vpn,
    input  logic               inst_en,
    input  logic [FRAME_W-1:0] inst_frame,
    input  logic [VPN_W-1:0]   inst_vpn,
    input  logic               inv_en,
    input  logic [FRAME_W-1:0] inv_frame,
    input  logic               slot_claim,
    input  logic               slot_release,
    input  logic [SLOT_W-1:0]  slot_rel_idx,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic               slot_avail
);
    logic [FRAMES-1:0]             match_vec, valid_vec, used_vec;
    logic [FRAMES-1:0][VPN_W-1:0]  vpn_vec;
    logic [FRAME_W-1:0]            hit_frame;
    logic                          any_hit;

    frame_cam #(.FRAMES(FRAMES), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_cam (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vpn(lk_vpn),
        .sweep_en(sweep_en), .inst_en(inst_en), .inst_frame(inst_frame),
        .inst_vpn(inst_vpn), .inv_en(inv_en), .inv_frame(inv_frame),
        .match_vec(match_vec), .valid_vec(valid_vec), .used_vec(used_vec),
        .vpn_vec(vpn_vec));

    lowest_set #(.N(FRAMES), .W(FRAME_W)) u_hit_enc (
        .vec(match_vec), .idx(hit_frame), .found(any_hit));

    victim_pick #(.FRAMES(FRAMES), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .used_vec(used_vec),
        .vpn_vec(vpn_vec), .alloc_frame(alloc_frame), .alloc_kind(alloc_kind),
        .evict_vpn(evict_vpn));

    slot_alloc #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .slot_claim(slot_claim),
        .slot_release(slot_release), .slot_rel_idx(slot_rel_idx),
        .slot_idx(slot_idx), .slot_avail(slot_avail));

    // Register the translation result: frame number joined with offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_en;
            rsp_hit   <= lk_en && any_hit;
            rsp_fault <= lk_en && !any_hit;
            rsp_paddr <= (lk_en && any_hit) ? {hit_frame, lk_off} : '0;
        end
    end

    // A result is exactly one of hit or fault.
    assert_hit_xor_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_fault));

    // No flags without a result.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_fault));

    // The translated offset field is the one presented.
    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_off)));
endmodule

// File: tb/sim_page_frame_dir.sv
// Self-checking bench: directed corners then seeded random traffic,
// compared against a bench-side reference model.
module sim_page_frame_dir;
    localparam int FRAMES = 32;
    localparam int VPN_W  = 8;
    localparam int OFF_W  = 9;
    localparam int SLOTS  = 192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_en = 0; logic [VPN_W-1:0] lk_vpn = 0; logic [OFF_W-1:0] lk_off = 0;
    logic sweep_en = 0;
    logic inst_en = 0; logic [4:0] inst_frame = 0; logic [VPN_W-1:0] inst_vpn = 0;
    logic inv_en = 0; logic [4:0] inv_frame = 0;
    logic slot_claim = 0, slot_release = 0; logic [7:0] slot_rel_idx = 0;
    logic rsp_valid, rsp_hit, rsp_fault, slot_avail;
    logic [13:0] rsp_paddr;
    logic [4:0] alloc_frame; logic [1:0] alloc_kind;
    logic [VPN_W-1:0] evict_vpn; logic [7:0] slot_idx;

    int checks = 0, fails = 0;
    bit done = 0;

    bit            m_valid [FRAMES];
    bit            m_used  [FRAMES];
    bit [VPN_W-1:0] m_vpn  [FRAMES];
    bit            m_occ   [SLOTS];

    always #2.5 clk = ~clk;

    page_frame_dir u0 (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .sweep_en(sweep_en), .alloc_frame(alloc_frame),
        .alloc_kind(alloc_kind), .evict_vpn(evict_vpn), .inst_en(inst_en),
        .inst_frame(inst_frame), .inst_vpn(inst_vpn), .inv_en(inv_en),
        .inv_frame(inv_frame), .slot_claim(slot_claim), .slot_release(slot_release),
        .slot_rel_idx(slot_rel_idx), .slot_idx(slot_idx), .slot_avail(slot_avail));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int find_vpn(logic [VPN_W-1:0] v);
        for (int f = 0; f < FRAMES; f++) if (m_valid[f] && m_vpn[f] == v) return f;
        return -1;
    endfunction

    function automatic int exp_frame(output int kind);
        for (int f = 0; f < FRAMES; f++) if (!m_valid[f]) begin kind = 0; return f; end
        for (int f = 0; f < FRAMES; f++) if (!m_used[f]) begin kind = 1; return f; end
        kind = 2;
        return 0;
    endfunction

    function automatic int exp_slot();
        for (int s = 0; s < SLOTS; s++) if (!m_occ[s]) return s;
        return -1;
    endfunction

    // One clock: check offers, clock, update model, check result.
    task automatic cycle();
        int kind, fr, sl, hf;
        logic [13:0] pa;
        #1;
        fr = exp_frame(kind);
        chk(kind == 0 ? "R4 frame" : "R5 frame", alloc_frame, fr);
        chk(kind == 0 ? "R4 kind" : "R5 kind", alloc_kind, kind);
        chk(kind == 0 ? "R4 evict" : "R5 evict", evict_vpn, kind == 0 ? 0 : m_vpn[fr]);
        sl = exp_slot();
        chk("R9 avail", slot_avail, sl >= 0);
        if (sl >= 0) chk("R9 idx", slot_idx, sl);
        hf = lk_en ? find_vpn(lk_vpn) : -1;
        pa = (hf >= 0) ? {5'(hf), lk_off} : '0;
        @(posedge clk);
        #1;
        for (int f = 0; f < FRAMES; f++) begin
            if (inst_en && inst_frame == 5'(f)) begin
                m_valid[f] = 1; m_used[f] = 1; m_vpn[f] = inst_vpn;
            end else if (inv_en && inv_frame == 5'(f)) begin
                m_valid[f] = 0; m_used[f] = 0;
            end else if (hf == f) m_used[f] = 1;
            else if (sweep_en) m_used[f] = 0;
        end
        if (slot_claim && sl >= 0) m_occ[sl] = 1;
        if (slot_release && slot_rel_idx < SLOTS) m_occ[slot_rel_idx] = 0;
        chk("R3 valid", rsp_valid, lk_en);
        chk(hf >= 0 ? "R2 hit" : "R3 hit", rsp_hit, hf >= 0);
        chk(hf >= 0 ? "R2 fault" : "R3 fault", rsp_fault, lk_en && hf < 0);
        chk(hf >= 0 ? "R2 paddr" : "R3 paddr", rsp_paddr, pa);
        @(negedge clk);
        lk_en = 0; sweep_en = 0; inst_en = 0; inv_en = 0;
        slot_claim = 0; slot_release = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int f = 0; f < FRAMES; f++) begin m_valid[f] = 0; m_used[f] = 0; m_vpn[f] = 0; end
        for (int s = 0; s < SLOTS; s++) m_occ[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_hit", rsp_hit, 0);
        chk("R1 rsp_fault", rsp_fault, 0);
        chk("R1 alloc_frame", alloc_frame, 0);
        chk("R1 alloc_kind", alloc_kind, 0);
        chk("R1 slot_idx", slot_idx, 0);
        chk("R1 slot_avail", slot_avail, 1);

        // R4/R7: fill every frame in order
        for (int f = 0; f < FRAMES; f++) begin
            inst_en = 1; inst_frame = alloc_frame; inst_vpn = 8'(f * 5 + 1);
            chk("R4 fill order", alloc_frame, f);
            cycle();
        end
        // R7: installed page of frame 3 translates
        lk_en = 1; lk_vpn = 8'd16; lk_off = 9'h1AB;
        cycle();
        chk("R7 installed hit", rsp_paddr, {5'd3, 9'h1AB});
        // R5: all used forces frame 0
        #1;
        chk("R5 forced kind", alloc_kind, 2);
        chk("R5 forced evict", evict_vpn, 1);
        // R6: sweep with a same-cycle hit on frame 0
        lk_en = 1; lk_vpn = 8'd1; sweep_en = 1;
        cycle();
        #1;
        chk("R6 sweep keeps hit frame", alloc_frame, 1);
        chk("R6 idle kind", alloc_kind, 1);
        chk("R6 evict page", evict_vpn, 6);
        // R8: invalidate frame 1, its page faults
        inv_en = 1; inv_frame = 5'd1;
        cycle();
        lk_en = 1; lk_vpn = 8'd6;
        cycle();
        chk("R8 fault after invalidate", rsp_fault, 1);
        chk("R8 frame reoffered", alloc_frame, 1);
        // R7: install beats invalidate on the same frame
        inst_en = 1; inst_frame = 5'd1; inst_vpn = 8'd200; inv_en = 1; inv_frame = 5'd1;
        cycle();
        lk_en = 1; lk_vpn = 8'd200; lk_off = 9'd7;
        cycle();
        chk("R7 install over invalidate", rsp_paddr, {5'd1, 9'd7});

        // R9: fill the secondary store, then free a middle slot
        for (int s = 0; s < SLOTS; s++) begin slot_claim = 1; cycle(); end
        #1;
        chk("R9 full", slot_avail, 0);
        slot_claim = 1;
        cycle();
        slot_release = 1; slot_rel_idx = 8'd100;
        cycle();
        #1;
        chk("R9 freed slot offered", slot_idx, 100);

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            int k;
            lk_en = ($urandom % 4) != 0;
            k = $urandom % FRAMES;
            lk_vpn = (($urandom % 2) && m_valid[k]) ? m_vpn[k] : 8'($urandom);
            lk_off = 9'($urandom);
            sweep_en = ($urandom % 16) == 0;
            if (($urandom % 4) == 0) begin
                logic [VPN_W-1:0] v;
                int kd, fr;
                v = 8'($urandom);
                fr = exp_frame(kd);
                if (find_vpn(v) < 0) begin inst_en = 1; inst_frame = 5'(fr); inst_vpn = v; end
            end
            if (($urandom % 16) == 0) begin inv_en = 1; inv_frame = 5'($urandom); end
            slot_claim = ($urandom % 3) == 0;
            if (($urandom % 4) == 0) begin
                slot_release = 1; slot_rel_idx = 8'($urandom % SLOTS);
                if (slot_claim && slot_rel_idx == 8'(exp_slot())) slot_release = 0;
            end
            cycle();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule